// File: doc/BRIEF.md
# Dual-Enable Static Memory Array

This block is a synchronous model of a byte-wide static memory with two chip enables of opposite polarity, an active-low output enable and a read/write line. The data port is split into an input bus, an output bus and an output-drive flag. The flag stands in for the tri-state control of a shared data pin. The output bus is held at zero whenever the flag is low, so a surrounding pad ring or bus mux can use the flag directly.

On every rising clock edge the control lines are decoded into one of four operating modes: standby, output-deselect, read and write. The decoded mode is loaded into a state register. All outputs come from that register, so the block also reports the power class of each cycle on a two-bit mode output. A write is committed on the same edge at which write mode is decoded. A read loads the addressed word into an output register on the edge at which read mode is decoded.

The depth is 2**ADDR_W words. The default build uses ADDR_W = 10 to keep elaboration light, and ADDR_W = 13 gives the full 8,192-word organisation. The array is split into 2**BANK_SEL_W banks, which are selected by the upper address bits.

Top module: `dual_enable_sram`

State register (mode_q) states: STANDBY (2'b00), DESELECT (2'b01), READ (2'b10), WRITE (2'b11). Every state can move to every other state on the next edge. The target state depends only on the controls sampled at that edge:
- to STANDBY when ce_n_i is high or ce_i is low;
- to WRITE when the part is selected and rw_i is low;
- to READ when the part is selected, rw_i is high and oe_n_i is low;
- to DESELECT when the part is selected, rw_i is high and oe_n_i is high.

Reset forces STANDBY.

## Requirements
- R1: While rst_n is low, and on the first edge after it falls, mode_o is 2'b00, dout_en_o is 0 and dout_o is 0.
- R2: When ce_n_i is high at a rising edge, mode_o becomes 2'b00 (standby) after that edge, whatever the other inputs are, and dout_en_o is 0.
- R3: When ce_i is low at a rising edge, mode_o becomes 2'b00 (standby) after that edge, whatever the other inputs are, and dout_en_o is 0.
- R4: With ce_n_i low, ce_i high, oe_n_i low and rw_i high at an edge, mode_o becomes 2'b10 (read), dout_en_o becomes 1, and dout_o carries the word stored at addr_i.
- R5: With ce_n_i low, ce_i high and rw_i low at an edge, mode_o becomes 2'b11 (write) for either value of oe_n_i. din_i is stored at addr_i on that edge, and dout_en_o is 0. A read of the same address on the next cycle returns the new word.
- R6: With ce_n_i low, ce_i high, oe_n_i high and rw_i high at an edge, mode_o becomes 2'b01 (deselect) and dout_en_o is 0.
- R7: No stored word changes at an edge decoded as standby, deselect or read, whatever addr_i and din_i carry.
- R8: dout_o is all zeros in every cycle in which dout_en_o is 0.
- R9: Every one of the 2**ADDR_W addresses holds its own word independently of all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the mode and output registers |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write data |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| rw_i | input | 1 | High selects read, low selects write |
| dout_o | output | DATA_W | Read data, zero when not driving |
| dout_en_o | output | 1 | High only in read mode (pin drive enable) |
| mode_o | output | 2 | 00 standby, 01 deselect, 10 read, 11 write |

## Verification
The hardest condition to bring about is one where a non-writing mode sees an address and data bus that would corrupt memory if the decode were wrong. This includes the standby rows with rw_i low and the read row with a fresh din_i. To reach it, the stimulus sweeps all sixteen control combinations. Each combination carries a poisoned data word aimed at a distinct, pre-filled address, and is followed by a read-back of that address. The same sweep covers writes with the output enable both low and high, and compares every cycle's mode against an arithmetic decode in the bench.

// File: rtl/dsram_pkg.sv
package dsram_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY  = 2'b00,
        MODE_DESELECT = 2'b01,
        MODE_READ     = 2'b10,
        MODE_WRITE    = 2'b11
    } mode_e;

endpackage

// File: rtl/dsram_ctrl_decode.sv
module dsram_ctrl_decode
    import dsram_pkg::*;
(
    input  logic  ce_n,
    input  logic  ce,
    input  logic  oe_n,
    input  logic  rw,
    output mode_e nxt_mode
);

    logic selected;

    assign selected = ~ce_n & ce;

    // Selection first, then the read/write line, then output enable.
    always_comb begin
        unique casez ({selected, rw, oe_n})
            3'b0??:  nxt_mode = MODE_STANDBY;
            3'b10?:  nxt_mode = MODE_WRITE;
            3'b110:  nxt_mode = MODE_READ;
            3'b111:  nxt_mode = MODE_DESELECT;
            default: nxt_mode = MODE_STANDBY;
        endcase
    end

endmodule

// File: rtl/dsram_bank.sv
module dsram_bank #(
    parameter int BANK_AW = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic               re,
    input  logic [BANK_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int BANK_WORDS = 1 << BANK_AW;

    logic [DATA_W-1:0] mem [BANK_WORDS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
    import dsram_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int BANK_SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ce_n_i,
    input  logic              ce_i,
    input  logic              oe_n_i,
    input  logic              rw_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o,
    output logic [1:0]        mode_o
);

    localparam int NUM_BANKS = 1 << BANK_SEL_W;
    localparam int BANK_AW   = ADDR_W - BANK_SEL_W;

    mode_e                 nxt_mode;
    mode_e                 mode_q;
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [BANK_SEL_W-1:0] bank_sel_q;
    logic [BANK_AW-1:0]    bank_addr;
    logic [DATA_W-1:0]     bank_rd [NUM_BANKS];

    assign bank_sel  = addr_i[ADDR_W-1 -: BANK_SEL_W];
    assign bank_addr = addr_i[BANK_AW-1:0];

    dsram_ctrl_decode u_decode (
        .ce_n     (ce_n_i),
        .ce       (ce_i),
        .oe_n     (oe_n_i),
        .rw       (rw_i),
        .nxt_mode (nxt_mode)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank_sel == BANK_SEL_W'(b));

        dsram_bank #(
            .BANK_AW (BANK_AW),
            .DATA_W  (DATA_W)
        ) u_bank (
            .clk   (clk),
            .we    (hit && (nxt_mode == MODE_WRITE)),
            .re    (hit && (nxt_mode == MODE_READ)),
            .addr  (bank_addr),
            .wdata (din_i),
            .rdata (bank_rd[b])
        );
    end

    // State register: holds the mode decoded at the last edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_STANDBY;
            bank_sel_q <= '0;
        end else begin
            mode_q <= nxt_mode;
            if (nxt_mode == MODE_READ) begin
                bank_sel_q <= bank_sel;
            end
        end
    end

    // Output process.
    always_comb begin
        unique case (mode_q)
            MODE_READ: begin
                dout_en_o = 1'b1;
                dout_o    = bank_rd[bank_sel_q];
            end
            MODE_WRITE: begin
                dout_en_o = 1'b0;
                dout_o    = '0;
            end
            MODE_DESELECT: begin
                dout_en_o = 1'b0;
                dout_o    = '0;
            end
            MODE_STANDBY: begin
                dout_en_o = 1'b0;
                dout_o    = '0;
            end
            default: begin
                dout_en_o = 1'b0;
                dout_o    = '0;
            end
        endcase
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/dsram_checker.sv
module dsram_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n_i,
    input logic              ce_i,
    input logic              oe_n_i,
    input logic              rw_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_en_o,
    input logic [1:0]        mode_o
);

    AST_RESET_STANDBY: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'b00 && !dout_en_o && dout_o == '0)); // R1

    AST_CE_N_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |=> (mode_o == 2'b00 && !dout_en_o)); // R2

    AST_CE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> (mode_o == 2'b00 && !dout_en_o)); // R3

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && ce_i && !oe_n_i && rw_i) |=> (mode_o == 2'b10 && dout_en_o)); // R4

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && ce_i && !rw_i) |=> (mode_o == 2'b11 && !dout_en_o)); // R5

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && ce_i && oe_n_i && rw_i) |=> (mode_o == 2'b01 && !dout_en_o)); // R6

    AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en_o |-> (dout_o == '0)); // R8

endmodule

bind dual_enable_sram dsram_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n_i    (ce_n_i),
    .ce_i      (ce_i),
    .oe_n_i    (oe_n_i),
    .rw_i      (rw_i),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o),
    .mode_o    (mode_o)
);

// File: tb/dual_enable_sram_tb.sv
module dual_enable_sram_tb;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_i;
    logic [DATA_W-1:0] din_i;
    logic              ce_n_i, ce_i, oe_n_i, rw_i;
    logic [DATA_W-1:0] dout_o;
    logic              dout_en_o;
    logic [1:0]        mode_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [DATA_W-1:0] ref_mem [DEPTH];

    always #4 clk = ~clk;

    dual_enable_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
        .ce_n_i(ce_n_i), .ce_i(ce_i), .oe_n_i(oe_n_i), .rw_i(rw_i),
        .dout_o(dout_o), .dout_en_o(dout_en_o), .mode_o(mode_o)
    );

    function automatic logic [DATA_W-1:0] pat(input int a);
        return DATA_W'((a * 37 + (a >> 3)) ^ 8'h5A);
    endfunction

    function automatic logic [1:0] exp_mode(input logic cn, input logic c,
                                            input logic on, input logic r);
        if (cn || !c) return 2'b00;
        if (!r)       return 2'b11;
        if (!on)      return 2'b10;
        return 2'b01;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply controls, take one rising edge, sample 2 ns later.
    task automatic op(input logic cn, input logic c, input logic on, input logic r,
                      input int a, input logic [DATA_W-1:0] d);
        ce_n_i = cn; ce_i = c; oe_n_i = on; rw_i = r;
        addr_i = ADDR_W'(a); din_i = d;
        @(posedge clk);
        #2;
    endtask

    task automatic read_back(input string req, input int a);
        op(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00);
        chk(req, int'(dout_o), int'(ref_mem[a]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ce_n_i = 1'b1; ce_i = 1'b0; oe_n_i = 1'b1; rw_i = 1'b1;
        addr_i = '0; din_i = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 mode", int'(mode_o), 0);
        chk("R1 en", int'(dout_en_o), 0);
        chk("R1 dout", int'(dout_o), 0);
        rst_n = 1'b1;

        // Fill every address, alternating the output enable (R5, R8, R9).
        for (int a = 0; a < DEPTH; a++) begin
            op(1'b0, 1'b1, a[0], 1'b0, a, pat(a));
            ref_mem[a] = pat(a);
            chk("R5 write mode", int'(mode_o), 3);
            chk("R8 dout zero on write", int'(dout_o), 0);
        end

        // Read every address back (R4, R9).
        for (int a = 0; a < DEPTH; a++) begin
            op(1'b0, 1'b1, 1'b0, 1'b1, a, ~pat(a));
            chk("R4 read mode", int'(mode_o), 2);
            chk("R4 read en", int'(dout_en_o), 1);
            chk("R9 read data", int'(dout_o), int'(ref_mem[a]));
        end

        // All 16 control rows with poisoned data, each followed by a read-back.
        for (int k = 0; k < 16; k++) begin
            automatic logic cn = k[3];
            automatic logic c  = k[2];
            automatic logic on = k[1];
            automatic logic r  = k[0];
            automatic int   a  = (k * 67 + 3) % DEPTH;
            automatic logic [1:0] em = exp_mode(cn, c, on, r);
            automatic string tag = cn ? "R2" : (!c ? "R3" : (em == 2'b11 ? "R5" :
                                   (em == 2'b10 ? "R4" : "R6")));
            op(cn, c, on, r, a, ~ref_mem[a]);
            chk({tag, " mode"}, int'(mode_o), int'(em));
            chk({tag, " en"}, int'(dout_en_o), (em == 2'b10) ? 1 : 0);
            chk({"R8 ", tag, " dout"}, int'(dout_o), (em == 2'b10) ? int'(ref_mem[a]) : 0);
            if (em == 2'b11) ref_mem[a] = ~ref_mem[a];
            read_back((em == 2'b11) ? "R5 read-back" : "R7 unchanged", a);
        end

        // Back-to-back write then read of the same and neighbouring addresses (R5, R9).
        op(1'b0, 1'b1, 1'b0, 1'b0, 5, 8'hC3);
        ref_mem[5] = 8'hC3;
        read_back("R5 back-to-back", 5);
        read_back("R9 neighbour", 4);
        read_back("R9 neighbour", 6);

        // Reset in the middle of read traffic (R1).
        op(1'b0, 1'b1, 1'b0, 1'b1, 5, 8'h00);
        rst_n = 1'b0;
        #1;
        chk("R1 async mode", int'(mode_o), 0);
        chk("R1 async dout", int'(dout_o), 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        read_back("R7 after reset", 5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule